// File: doc/BRIEF.md
# UART receiver with line status

This block turns an asynchronous serial line into received characters and keeps the error status a processor needs to judge them. It samples the line on a 16x oversampling tick, finds start bits by checking the middle of the bit, and shifts in 5 to 8 data bits, LSB first. It then takes an optional parity bit and checks the stop bit. Each completed character carries three error tags: parity, framing and break. The character and its tags go either into a single holding register or, when FIFO mode is on, into a 16-entry queue.

The processor takes characters with a one-cycle data-read strobe. It reads the error flags with a one-cycle status-read strobe, which also clears them. A character's tags reach the status flags only when that character is at the head of storage. So in FIFO mode an error is reported against the right character. Any of the overrun, parity, framing or break flags raises an interrupt when the interrupt enable is high.

After a bad stop bit the receiver treats that low level as the start bit of the next character, so a stream that has slipped by one bit is picked up again. A line held low for longer than a full frame gives exactly one zero character. Reception resumes only after the line has gone high again and a new start bit arrives.

Top module: `uart_rx_status`

## Requirements
- R1: A frame is a low start bit, then `cfg_wlen`+5 data bits LSB first (code 0..3 = 5..8 bits), then a parity bit if `cfg_par_en`, then a high stop bit, each bit lasting 16 `os_tick` pulses. The character appears right-aligned on `rx_byte`, with the unused upper bits zero, and `data_ready` is high while storage holds at least one character.
- R2: With `fifo_en` low, a character that completes while the holding register is still unread replaces it, and `flag_overrun` goes high.
- R3: With `cfg_par_en` high, a character whose parity bit makes the total count of ones odd (`cfg_par_even`=1) or even (`cfg_par_even`=0) is tagged with a parity error.
- R4: A character whose stop bit is sampled low is tagged with a framing error.
- R5: After a framing error the low stop level is taken as the next start bit, so a character whose start bit occupies the stop-bit slot of the previous one is received correctly.
- R6: With `fifo_en` high, up to 16 characters are kept in arrival order. A character that completes while all 16 are held is discarded, and `flag_overrun` goes high.
- R7: A character's parity, framing and break tags set `flag_parity`, `flag_framing` and `flag_break` only once that character is at the head of storage.
- R8: A `rd_status` pulse clears all four flags. A `rd_data` pulse removes the head character.
- R9: `err_irq` is high exactly when `err_irq_en` is high and at least one of the four flags is set.
- R10: A line held low through every sample point of a frame (through the second stop bit when `cfg_stop2` is set) stores one zero character tagged only as a break. No further character is taken until the line returns high and a new start bit is seen.
- R11: A low pulse that has ended by the mid-bit sample of the start bit stores nothing.
- R12: After reset, `data_ready`, all four flags and `err_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial data line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop2 | input | 1 | Two stop bits (lengthens break detection) |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| rd_data | input | 1 | Removes the head character |
| rd_status | input | 1 | Status read, clears the flags |
| err_irq_en | input | 1 | Line status interrupt enable |
| rx_byte | output | 8 | Head character |
| data_ready | output | 1 | Storage not empty |
| flag_overrun | output | 1 | A character was lost |
| flag_parity | output | 1 | Head-reported parity error |
| flag_framing | output | 1 | Head-reported framing error |
| flag_break | output | 1 | Head-reported break |
| err_irq | output | 1 | Line status interrupt |

## Verification
Clean frames at 5, 7 and 8 data bits, with odd, even and no parity, establish that the basic width and parity handling is right. A deliberately wrong parity bit, and a low stop bit immediately followed by a real frame, separate tag generation from the resynchronisation path. Unread back-to-back characters, run in holding mode and in a queue filled past 16, tell overwrite apart from discard. A line held low past a frame, and a short low glitch, tell break handling apart from start-bit rejection. The interrupt is tried with its enable both low and high.

// File: rtl/urs_pkg.sv
package urs_pkg;
   localparam int URS_DW = 8;

   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } urs_tags_t;

   typedef struct packed {
      logic [URS_DW-1:0] data;
      urs_tags_t         tags;
   } urs_entry_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_STOP2, ST_HOLD
   } urs_state_e;
endpackage

// File: rtl/urs_framer.sv
module urs_framer
   import urs_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                rxd,
   input  logic [1:0]          wlen,
   input  logic                par_en,
   input  logic                par_even,
   input  logic                stop2,
   output logic                push,
   output logic [URS_DW-1:0]   push_data,
   output urs_tags_t           push_tags
);
   localparam int CW = $clog2(OSR);
   localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OSR - 1);

   initial assert (OSR >= 4 && OSR % 2 == 0) else $error("OSR must be even and at least 4");
   initial assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4) else $error("SYNC_STAGES out of range");

   logic rx_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rx_s = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '1;
            else        sr_q <= (sr_q << 1) | SYNC_STAGES'(rxd);
         end
         assign rx_s = sr_q[SYNC_STAGES-1];
      end
   endgenerate

   urs_state_e        state_q;
   logic [CW-1:0]     cnt_q;
   logic [2:0]        bit_q;
   logic [URS_DW-1:0] sh_q;
   logic              allz_q;
   logic              pbit_q;
   logic              push_q;
   urs_tags_t         tags_q;

   logic [2:0]    last_idx;
   logic          bit_end;
   logic [CW-1:0] nxt_cnt;
   logic          perr;

   assign last_idx = 3'(wlen) + 3'd4;
   assign bit_end  = (cnt_q == LAST);
   assign nxt_cnt  = bit_end ? '0 : cnt_q + 1'b1;
   assign perr     = par_en & (^sh_q ^ pbit_q ^ ~par_even);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         sh_q    <= '0;
         allz_q  <= 1'b0;
         pbit_q  <= 1'b0;
         push_q  <= 1'b0;
         tags_q  <= '0;
      end else begin
         push_q <= 1'b0;
         if (tick) begin
            case (state_q)
               ST_IDLE: begin
                  if (!rx_s) begin
                     state_q <= ST_START;
                     cnt_q   <= '0;
                  end
               end
               ST_START: begin
                  if (cnt_q == MID) begin
                     if (!rx_s) begin
                        state_q <= ST_DATA;
                        cnt_q   <= '0;
                        bit_q   <= '0;
                        sh_q    <= '0;
                        allz_q  <= 1'b1;
                        pbit_q  <= 1'b0;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_DATA: begin
                  cnt_q <= nxt_cnt;
                  if (bit_end) begin
                     sh_q[bit_q] <= rx_s;
                     allz_q      <= allz_q & ~rx_s;
                     if (bit_q == last_idx) state_q <= par_en ? ST_PAR : ST_STOP;
                     else                   bit_q   <= bit_q + 1'b1;
                  end
               end
               ST_PAR: begin
                  cnt_q <= nxt_cnt;
                  if (bit_end) begin
                     pbit_q  <= rx_s;
                     allz_q  <= allz_q & ~rx_s;
                     state_q <= ST_STOP;
                  end
               end
               ST_STOP: begin
                  cnt_q <= nxt_cnt;
                  if (bit_end) begin
                     if (rx_s) begin
                        push_q  <= 1'b1;
                        tags_q  <= '{brk: 1'b0, frm: 1'b0, par: perr};
                        state_q <= ST_IDLE;
                     end else if (allz_q) begin
                        if (stop2) begin
                           state_q <= ST_STOP2;
                        end else begin
                           push_q  <= 1'b1;
                           tags_q  <= '{brk: 1'b1, frm: 1'b0, par: 1'b0};
                           state_q <= ST_HOLD;
                        end
                     end else begin
                        push_q  <= 1'b1;
                        tags_q  <= '{brk: 1'b0, frm: 1'b1, par: perr};
                        state_q <= ST_START;
                        cnt_q   <= MID;
                     end
                  end
               end
               ST_STOP2: begin
                  cnt_q <= nxt_cnt;
                  if (bit_end) begin
                     push_q <= 1'b1;
                     if (!rx_s) begin
                        tags_q  <= '{brk: 1'b1, frm: 1'b0, par: 1'b0};
                        state_q <= ST_HOLD;
                     end else begin
                        tags_q  <= '{brk: 1'b0, frm: 1'b1, par: perr};
                        state_q <= ST_IDLE;
                     end
                  end
               end
               ST_HOLD: begin
                  if (rx_s) state_q <= ST_IDLE;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign push      = push_q;
   assign push_data = sh_q;
   assign push_tags = tags_q;

   // R10
   brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push && push_tags.brk |-> (push_data == '0) && !push_tags.frm);

   // R11
   false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick && state_q == ST_START && cnt_q == MID && rx_s |=> state_q == ST_IDLE && !push);
endmodule

// File: rtl/urs_store.sv
module urs_store
   import urs_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fifo_en,
   input  logic        push,
   input  urs_entry_t  push_entry,
   input  logic        pop_req,
   output urs_entry_t  head,
   output logic        not_empty,
   output logic        ovr,
   output logic        head_new
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   initial assert (DEPTH >= 2) else $error("DEPTH must be at least 2");

   urs_entry_t    mem_q [DEPTH];
   logic [AW-1:0] wr_ptr_q, rd_ptr_q;
   logic [CW-1:0] count_q;
   logic          fifo_en_q;
   logic          head_new_q;

   logic          flush, cap_full, do_pop, accept, overwrite;
   logic [AW-1:0] wr_idx;

   function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign flush     = (fifo_en != fifo_en_q);
   assign cap_full  = fifo_en ? (count_q == FULL) : (count_q != '0);
   assign do_pop    = pop_req && (count_q != '0) && !flush;
   assign accept    = push && (!cap_full || do_pop) && !flush;
   assign overwrite = push && cap_full && !do_pop && !fifo_en && !flush;
   assign ovr       = push && cap_full && !do_pop && !flush;
   assign wr_idx    = overwrite ? rd_ptr_q : wr_ptr_q;

   always_ff @(posedge clk) begin
      if (accept || overwrite) mem_q[wr_idx] <= push_entry;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q   <= '0;
         rd_ptr_q   <= '0;
         count_q    <= '0;
         fifo_en_q  <= 1'b0;
         head_new_q <= 1'b0;
      end else begin
         fifo_en_q <= fifo_en;
         if (flush) begin
            wr_ptr_q   <= '0;
            rd_ptr_q   <= '0;
            count_q    <= '0;
            head_new_q <= 1'b0;
         end else begin
            if (accept) wr_ptr_q <= ptr_inc(wr_ptr_q);
            if (do_pop) rd_ptr_q <= ptr_inc(rd_ptr_q);
            count_q    <= count_q + CW'(accept) - CW'(do_pop);
            head_new_q <= overwrite
                        || (do_pop && count_q > CW'(1))
                        || (accept && (count_q == '0 || (do_pop && count_q == CW'(1))));
         end
      end
   end

   assign head      = mem_q[rd_ptr_q];
   assign not_empty = (count_q != '0);
   assign head_new  = head_new_q;

   // R6
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL);

   // R6
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en && fifo_en_q && push && count_q == FULL && !pop_req |=> count_q == FULL);

   // R2
   hold_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en && !fifo_en_q && push && count_q == CW'(1) && !pop_req
      |=> count_q == CW'(1) && head == $past(push_entry));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
   import urs_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rxd,
   input  logic       os_tick,
   input  logic [1:0] cfg_wlen,
   input  logic       cfg_par_en,
   input  logic       cfg_par_even,
   input  logic       cfg_stop2,
   input  logic       fifo_en,
   input  logic       rd_data,
   input  logic       rd_status,
   input  logic       err_irq_en,
   output logic [7:0] rx_byte,
   output logic       data_ready,
   output logic       flag_overrun,
   output logic       flag_parity,
   output logic       flag_framing,
   output logic       flag_break,
   output logic       err_irq
);
   logic              f_push;
   logic [URS_DW-1:0] f_data;
   urs_tags_t         f_tags;
   urs_entry_t        f_entry;
   urs_entry_t        head;
   logic              s_ne, s_ovr, s_head_new;

   urs_framer #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (os_tick),
      .rxd       (rxd),
      .wlen      (cfg_wlen),
      .par_en    (cfg_par_en),
      .par_even  (cfg_par_even),
      .stop2     (cfg_stop2),
      .push      (f_push),
      .push_data (f_data),
      .push_tags (f_tags)
   );

   assign f_entry = '{data: f_data, tags: f_tags};

   urs_store #(.DEPTH(DEPTH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_en    (fifo_en),
      .push       (f_push),
      .push_entry (f_entry),
      .pop_req    (rd_data),
      .head       (head),
      .not_empty  (s_ne),
      .ovr        (s_ovr),
      .head_new   (s_head_new)
   );

   logic oe_q, pe_q, fe_q, bi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q <= 1'b0;
         pe_q <= 1'b0;
         fe_q <= 1'b0;
         bi_q <= 1'b0;
      end else begin
         oe_q <= s_ovr | (oe_q & ~rd_status);
         pe_q <= (s_head_new & head.tags.par) | (pe_q & ~rd_status);
         fe_q <= (s_head_new & head.tags.frm) | (fe_q & ~rd_status);
         bi_q <= (s_head_new & head.tags.brk) | (bi_q & ~rd_status);
      end
   end

   assign rx_byte      = head.data;
   assign data_ready   = s_ne;
   assign flag_overrun = oe_q;
   assign flag_parity  = pe_q;
   assign flag_framing = fe_q;
   assign flag_break   = bi_q;
   assign err_irq      = err_irq_en & (oe_q | pe_q | fe_q | bi_q);

   // R8
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_status && !s_ovr |=> !flag_overrun);

   // R8
   tag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_status && !s_head_new |=> !flag_parity && !flag_framing && !flag_break);

   // R7
   tag_at_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s_head_new && !flag_parity |=> !flag_parity);
endmodule

// File: tb/sim_uart_rx_status.sv
module sim_uart_rx_status;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       os_tick = 1'b0;
   logic [1:0] cfg_wlen = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_even = 1'b0;
   logic       cfg_stop2 = 1'b0;
   logic       fifo_en = 1'b0;
   logic       rd_data = 1'b0;
   logic       rd_status = 1'b0;
   logic       err_irq_en = 1'b1;
   logic [7:0] rx_byte;
   logic       data_ready, flag_overrun, flag_parity, flag_framing, flag_break, err_irq;

   always #2 clk = ~clk;
   always @(posedge clk) os_tick <= ~os_tick;

   uart_rx_status u0 (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
      .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
      .cfg_stop2(cfg_stop2), .fifo_en(fifo_en), .rd_data(rd_data),
      .rd_status(rd_status), .err_irq_en(err_irq_en), .rx_byte(rx_byte),
      .data_ready(data_ready), .flag_overrun(flag_overrun), .flag_parity(flag_parity),
      .flag_framing(flag_framing), .flag_break(flag_break), .err_irq(err_irq)
   );

   int n_chk = 0;
   int n_fail = 0;

   // reference model: queue of {data, brk, frm, par}
   logic [10:0] mq[$];
   bit m_oe, m_pe, m_fe, m_bi;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic void m_apply(input logic [10:0] e);
      m_bi |= e[2];
      m_fe |= e[1];
      m_pe |= e[0];
   endfunction

   function automatic void m_push(input logic [7:0] d, input logic [2:0] tg);
      logic [10:0] e = {d, tg};
      if (fifo_en) begin
         if (mq.size() == 16) m_oe = 1'b1;
         else begin
            mq.push_back(e);
            if (mq.size() == 1) m_apply(e);
         end
      end else if (mq.size() == 1) begin
         m_oe = 1'b1;
         mq[0] = e;
         m_apply(e);
      end else begin
         mq.push_back(e);
         m_apply(e);
      end
   endfunction

   task automatic cmp_all(input string tag);
      chk({tag, " data_ready"}, 32'(data_ready), 32'(mq.size() != 0));
      if (mq.size() != 0) chk({tag, " rx_byte"}, 32'(rx_byte), 32'(mq[0][10:3]));
      chk({tag, " overrun"}, 32'(flag_overrun), 32'(m_oe));
      chk({tag, " parity"},  32'(flag_parity),  32'(m_pe));
      chk({tag, " framing"}, 32'(flag_framing), 32'(m_fe));
      chk({tag, " break"},   32'(flag_break),   32'(m_bi));
      chk({tag, " irq R9"},  32'(err_irq), 32'(err_irq_en & (m_oe | m_pe | m_fe | m_bi)));
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      rxd = b;
      repeat (31) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_low);
      int nb = int'(cfg_wlen) + 5;
      logic [7:0] dm = d & (8'hFF >> (3 - int'(cfg_wlen)));
      logic pb;
      send_bit(1'b0);
      for (int i = 0; i < nb; i++) send_bit(dm[i]);
      if (cfg_par_en) begin
         pb = (^dm) ^ ~cfg_par_even ^ bad_par;
         send_bit(pb);
      end
      m_push(dm, {1'b0, stop_low, bad_par & cfg_par_en});
      if (!stop_low) begin
         send_bit(1'b1);
         if (cfg_stop2) send_bit(1'b1);
         send_bit(1'b1);
      end
   endtask

   task automatic pop_byte();
      @(negedge clk); rd_data = 1'b1;
      @(negedge clk); rd_data = 1'b0;
      if (mq.size() != 0) begin
         void'(mq.pop_front());
         if (mq.size() != 0) m_apply(mq[0]);
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic read_status();
      @(negedge clk); rd_status = 1'b1;
      @(negedge clk); rd_status = 1'b0;
      m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      cmp_all("R12 reset");

      // 8N1 holding register
      send_frame(8'hA5, 0, 0);
      cmp_all("R1 8-bit char");
      pop_byte();
      cmp_all("R8 pop empties");

      // 5 data bits, odd parity, upper bits zero
      cfg_wlen = 2'd0; cfg_par_en = 1'b1; cfg_par_even = 1'b0;
      send_frame(8'hFF, 0, 0);
      cmp_all("R1 5-bit odd parity");
      chk("R1 upper bits zero", 32'(rx_byte), 32'h1F);
      pop_byte();

      // 7 data bits, even parity, wrong parity bit
      cfg_wlen = 2'd2; cfg_par_even = 1'b1;
      send_frame(8'h35, 0, 0);
      cmp_all("R3 7-bit even good");
      pop_byte();
      send_frame(8'h5A, 1, 0);
      cmp_all("R3 parity error");
      read_status();
      cmp_all("R8 status clears parity");
      pop_byte();

      // overrun in holding mode, interrupt gating
      cfg_wlen = 2'd3; cfg_par_en = 1'b0; err_irq_en = 1'b0;
      send_frame(8'h11, 0, 0);
      send_frame(8'h22, 0, 0);
      cmp_all("R2 holding overwrite");
      chk("R9 irq masked", 32'(err_irq), 32'h0);
      @(negedge clk); err_irq_en = 1'b1;
      @(negedge clk);
      cmp_all("R9 irq enabled");
      read_status();
      cmp_all("R8 status clears overrun");
      pop_byte();

      // FIFO mode: low stop bit is the next start bit
      fifo_en = 1'b1;
      repeat (4) @(negedge clk);
      send_frame(8'h3C, 0, 1);
      send_frame(8'hC3, 0, 0);
      cmp_all("R4 framing error head");
      read_status();
      pop_byte();
      cmp_all("R5 resync char");
      chk("R5 resync byte", 32'(rx_byte), 32'hC3);
      pop_byte();

      // per-character tags in FIFO
      cfg_par_en = 1'b1; cfg_par_even = 1'b1;
      send_frame(8'h11, 0, 0);
      send_frame(8'h22, 1, 0);
      send_frame(8'h33, 0, 0);
      cmp_all("R7 clean head hides later error");
      pop_byte();
      cmp_all("R7 error shows at head");
      read_status();
      cmp_all("R8 clear with char at head");
      pop_byte();
      cmp_all("R7 next clean head");
      pop_byte();

      // break with two stop bits
      cfg_par_en = 1'b0; cfg_stop2 = 1'b1;
      for (int i = 0; i < 12; i++) send_bit(1'b0);
      m_push(8'h00, 3'b100);
      send_bit(1'b1);
      send_bit(1'b1);
      cmp_all("R10 break char");
      pop_byte();
      cmp_all("R10 only one break char");
      read_status();
      send_frame(8'h77, 0, 0);
      cmp_all("R10 resume after break");
      pop_byte();

      // short low glitch
      cfg_stop2 = 1'b0;
      @(negedge clk); rxd = 1'b0;
      repeat (6) @(negedge clk);
      rxd = 1'b1;
      repeat (96) @(negedge clk);
      cmp_all("R11 glitch ignored");

      // fill FIFO past depth
      for (int i = 0; i < 17; i++) send_frame(8'(8'h40 + i), 0, 0);
      cmp_all("R6 full then overrun");
      for (int i = 0; i < 16; i++) begin
         chk("R6 order", 32'(rx_byte), 32'(8'h40 + i));
         pop_byte();
      end
      cmp_all("R6 dropped char absent");

      finish_run();
   end
endmodule